// File: doc/BRIEF.md
# Trigger-Started One-Shot Pulse Timer

This block places a single output pulse at a programmable delay after an external trigger edge. A rising edge on the asynchronous trigger input is synchronized and edge-detected. The edge then loads a down-counter from a held reload value. The counter runs once to zero and stops.

The output pulse is tied to the end of the count. It is active while the count is at or below a compare value, so the compare value sets the pulse width directly and the reload value sets the whole trigger-to-end period. The trigger path has a fixed two-cycle latency. To get an off-time `Toff` followed by an on-time `Ton`, program the compare value as `Ton - 1` and the reload value as `Toff + Ton - 3`.

A busy flag shows when the counter is running. A one-cycle end strobe marks the end of each shot.

Top module: `trig_pulse_timer`

## Requirements
- R1: While reset is held and right after it, `pulse_out`, `busy` and `done` are 0, output enable is off, the compare value is 0 and the held reload value is all ones (65535 for the default 16-bit width).
- R2: If `trig_in` is sampled high at clock edge k after being sampled low at edge k-1, the counter loads the held reload value at edge k+2 and `busy` is 1 from then on.
- R3: A started run keeps `busy` high for exactly reload+1 cycles. The count goes from the reload value down to 0 by one per cycle. The run then stops and does not restart by itself.
- R4: With output enable on, `pulse_out` is 1 exactly in the cycles where `busy` is 1 and the current count is less than or equal to the compare value. This means it covers the last compare+1 cycles of the run, or the whole run when compare is greater than reload.
- R5: With output enable off, `pulse_out` stays 0, while `busy` and `done` behave as in R2, R3 and R6.
- R6: `done` is a one-cycle strobe in the first cycle after the last busy cycle. It is never high at any other time.
- R7: A trigger rising edge that reaches the counter while it is running has no effect. A trigger held high past the end of a run does not start a new run.
- R8: A reload write only updates the held value. A write during a run leaves that run's length unchanged, and the new value is used by the next triggered run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger; rising edge starts a run |
| reload_we | input | 1 | Write strobe for the held reload value |
| reload_val | input | W | Reload value written on `reload_we` |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_val | input | W | Compare value written on `cmp_we` |
| oen_we | input | 1 | Write strobe for the output enable |
| oen_val | input | 1 | Output enable written on `oen_we` (1 = pulse allowed) |
| pulse_out | output | 1 | Pulse output |
| busy | output | 1 | Counter running |
| done | output | 1 | One-cycle end-of-run strobe |

## Verification
Time in the bench counts from the first clock edge that samples the trigger high. At a negative edge after t such edges:
- `busy` must rise at t=3.
- `busy` must hold through t=reload+3, with `pulse_out` following the count reload-(t-3) against the compare value.
- `done` must appear only at t=reload+4.

Each shot is checked at every one of these negedges through t=reload+6. Stimulus is driven on negative edges, and each cycle's expected outputs come from bench functions of t, the reload, the compare and the enable. The checks therefore fall exactly on the cycle where each registered output changes. Extra trigger edges are injected early enough in a run to reach the counter while it is still busy, and held triggers are kept high past the end of the run, so that R7 shows up as the absence of a second busy period.

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer #(
  parameter int W = 16,
  parameter logic [W-1:0] RELOAD_RST = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig_in,
  input  logic         reload_we,
  input  logic [W-1:0] reload_val,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_val,
  input  logic         oen_we,
  input  logic         oen_val,
  output logic         pulse_out,
  output logic         busy,
  output logic         done
);

  localparam logic [W-1:0] ZERO = '0;

  logic [2:0]   sync_q;
  logic [W-1:0] reload_q, cmp_q, cnt_q;
  logic         oen_q, run_q, done_q;
  logic         rise, start, at_zero;

  assign rise    = sync_q[1] & ~sync_q[2];
  assign start   = rise & ~run_q;
  assign at_zero = (cnt_q == ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], trig_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      cmp_q    <= ZERO;
      oen_q    <= 1'b0;
    end else begin
      if (reload_we) reload_q <= reload_val;
      if (cmp_we)    cmp_q    <= cmp_val;
      if (oen_we)    oen_q    <= oen_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_q & at_zero;
      if (start) begin
        cnt_q <= reload_q;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (at_zero) run_q <= 1'b0;
        else         cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy      = run_q;
  assign done      = done_q;
  assign pulse_out = run_q & oen_q & (cnt_q <= cmp_q);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(rise) && cnt_q == $past(reload_q)));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_zero) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

  // R3
  stop_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && at_zero && !rise) |=> !run_q);

  // R5
  oen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oen_q |-> !pulse_out);

  // R4
  pulse_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> busy);

  // R6
  done_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !$past(done)));

  // R7
  ignore_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_zero && rise) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_zero && reload_we) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: tb/trig_pulse_timer_tb.sv
module trig_pulse_timer_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 1'b0;
  logic reload_we = 1'b0, cmp_we = 1'b0, oen_we = 1'b0, oen_val = 1'b0;
  logic [W-1:0] reload_val = '0, cmp_val = '0;
  logic pulse_out, busy, done;

  int checks = 0;
  int errors = 0;
  int sh_m = 65535;
  int cmp_m = 0;
  bit oen_m = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trig_pulse_timer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .reload_we(reload_we), .reload_val(reload_val),
    .cmp_we(cmp_we), .cmp_val(cmp_val),
    .oen_we(oen_we), .oen_val(oen_val),
    .pulse_out(pulse_out), .busy(busy), .done(done)
  );

  function automatic bit exp_busy(int t, int r);
    return (t >= 3) && (t <= r + 3);
  endfunction

  function automatic bit exp_pulse(int t, int r, int cp, bit en);
    return exp_busy(t, r) && en && ((r - (t - 3)) <= cp);
  endfunction

  function automatic bit exp_done(int t, int r);
    return t == r + 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_reload(int v);
    @(negedge clk); reload_we = 1'b1; reload_val = W'(v);
    @(negedge clk); reload_we = 1'b0;
    sh_m = v;
  endtask

  task automatic wr_cfg(int cp, bit en);
    @(negedge clk); cmp_we = 1'b1; cmp_val = W'(cp); oen_we = 1'b1; oen_val = en;
    @(negedge clk); cmp_we = 1'b0; oen_we = 1'b0;
    cmp_m = cp; oen_m = en;
  endtask

  task automatic shot(int tw, bit noise, bit midw, int newrl, string btag);
    int r;
    string tg;
    r = sh_m;
    @(negedge clk); trig_in = 1'b1;
    for (int t = 1; t <= r + 6; t++) begin
      @(negedge clk);
      if (btag != "")        tg = btag;
      else if (noise || tw > 3) tg = "R7";
      else if (midw)         tg = "R8";
      else if (t <= 3)       tg = "R2";
      else                   tg = "R3";
      chk(tg, busy, exp_busy(t, r));
      chk(oen_m ? "R4" : "R5", pulse_out, exp_pulse(t, r, cmp_m, oen_m));
      chk("R6", done, exp_done(t, r));
      if (t == tw) trig_in = 1'b0;
      if (noise && t == 5) trig_in = 1'b1;
      if (noise && t == 6) trig_in = 1'b0;
      if (midw && t == 4) begin reload_we = 1'b1; reload_val = W'(newrl); end
      if (midw && t == 5) begin reload_we = 1'b0; sh_m = newrl; end
    end
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", busy, 0);
  endtask

  initial begin
    int rl, cp, tw;
    bit en, nz;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", pulse_out, 0);
    chk("R1", busy, 0);
    chk("R1", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", busy, 0);
    chk("R1", done, 0);
    cmp_m = 0; oen_m = 1'b0; sh_m = 65535;
    shot(2, 1'b0, 1'b0, 0, "R1");

    wr_cfg(0, 1'b1); wr_reload(0);   shot(1, 1'b0, 1'b0, 0, "");
    wr_cfg(5, 1'b1); wr_reload(5);   shot(1, 1'b0, 1'b0, 0, "");
    wr_cfg(9, 1'b1); wr_reload(4);   shot(2, 1'b0, 1'b0, 0, "");
    wr_cfg(3, 1'b0); wr_reload(20);  shot(1, 1'b0, 1'b0, 0, "");
    wr_cfg(7, 1'b1); wr_reload(30);  shot(35, 1'b0, 1'b0, 0, "");
    wr_cfg(4, 1'b1); wr_reload(25);  shot(2, 1'b1, 1'b0, 0, "");
    wr_cfg(2, 1'b1); wr_reload(40);  shot(1, 1'b0, 1'b1, 12, "");
    shot(1, 1'b0, 1'b0, 0, "R8");

    for (int i = 0; i < 60; i++) begin
      rl = $urandom % 200;
      cp = $urandom % 220;
      en = ($urandom % 4) != 0;
      nz = (rl >= 10) && (($urandom % 3) == 0);
      if (nz) tw = 1 + $urandom % 3;
      else if (($urandom % 4) == 0) tw = rl + 5;
      else tw = 1 + $urandom % 3;
      wr_cfg(cp, en);
      wr_reload(rl);
      shot(tw, nz, 1'b0, 0, "");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule